// File: doc/BRIEF.md
# VBUS Protection Switch Sequencer

This block is the digital controller behind a power-path load switch on a USB charger input. External comparators supply an undervoltage flag and an overvoltage flag, both with their hysteresis handled in the analog domain. The overvoltage side also supplies a small code for how far the input is above the limit. A die temperature code in whole degrees Celsius and an active-low enable complete the inputs. The block decides when the switch may close. It also drives a status line that is pulled low while the input is healthy and released otherwise. That line is modelled here as an output-enable for an open-drain pin.

A prescaler turns the clock into ticks, and a fixed number of ticks makes one millisecond. The switch closes only after the input has been fault-free for a continuous recovery window. The window is 17 ms at start-up, after an undervoltage fault and after a thermal fault, and 8 ms after an overvoltage fault. If any fault appears during a window, the window starts again from zero. Overvoltage is not acted on directly. A saturating integrator climbs faster for a larger excursion and drains slowly, so short spikes are ignored while a large surge trips quickly. Thermal shutdown trips above 145 °C and releases only below 120 °C.

Top module: `vbus_guard_seq`

## Requirements
- R1: While reset is active, and after it is released, ackPullLow=0 and swOn=0. With no fault and enN=0, ackPullLow and swOn rise exactly LONG_MS*TICKS_PER_MS ticks after reset is released.
- R2: If uvFlag=1 at a clock edge, ackPullLow=0 and swOn=0 from that edge onward. After uvFlag returns to 0, ackPullLow rises on the LONG_MS*TICKS_PER_MS-th tick edge with no fault present.
- R3: After an overvoltage fault ends (the integrator drops below TRIP_LEVEL), ackPullLow rises after a further SHORT_MS*TICKS_PER_MS fault-free ticks.
- R4: Any fault during a recovery window, even for a single cycle, restarts the window from zero.
- R5: swOn equals ackPullLow AND NOT enN. enN has no effect on ackPullLow.
- R6: A die temperature code above 145 latches a thermal fault one edge later. The fault clears only on a code below 120, so codes from 120 to 145 hold the current state. Recovery from a thermal fault takes LONG_MS*TICKS_PER_MS ticks.
- R7: The overvoltage integrator rises by 1+ovMag on each tick while ovFlag=1, saturating at TRIP_LEVEL, and falls by 1 on each tick while ovFlag=0, stopping at 0. The overvoltage fault is active while the integrator equals TRIP_LEVEL. From an empty integrator, a steady excursion trips after ceil(TRIP_LEVEL/(1+ovMag)) ticks, and a shorter pulse does not trip.
- R8: Fault priority is thermal, then undervoltage, then overvoltage. The recovery length is LONG unless overvoltage was the highest-priority fault in the last faulty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvFlag | input | 1 | Undervoltage comparator output, 1 = below limit |
| ovFlag | input | 1 | Overvoltage comparator output, 1 = above limit |
| ovMag | input | MAG_W | Overvoltage excursion magnitude code |
| dieTemp | input | TEMP_W | Die temperature in °C, unsigned |
| enN | input | 1 | Active-low switch enable |
| swOn | output | 1 | Load switch gate command, 1 = closed |
| ackPullLow | output | 1 | 1 = status pin driven low (input healthy); 0 = released |

## Verification
A wrong integrator value or step shows up as an ackPullLow fall that comes one or more ticks early or late against ceil(TRIP_LEVEL/(1+ovMag))+1 edges. It can also show up as a fall during a short pulse that should have been rejected. The sweep over every magnitude code catches this on the first affected code. A wrong delay length, a wrong recovery selection or a wrong restart shows up as an ackPullLow rise off by at least one edge. Each window is bracketed on both sides of its expected edge, so such an error appears within one recovery window. A wrong thermal latch shows up as a release or a recovery at a temperature code on the wrong side of 145 or 120.

// File: rtl/vbus_seq_pkg.sv
package vbus_seq_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_THERM = 2'd1,
    FLT_UNDER = 2'd2,
    FLT_OVER  = 2'd3
  } faultSrc_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic clrWait;   // fault present: zero the recovery counter
    logic stepWait;  // count one fault-free tick
    logic useLong;   // select long recovery window
  } seqStrobe_t;

endpackage

// File: rtl/vbus_seq_datapath.sv
module vbus_seq_datapath
  import vbus_seq_pkg::*;
#(
  parameter int CLK_PER_TICK = 125,
  parameter int TICKS_PER_MS = 1000,
  parameter int LONG_MS      = 17,
  parameter int SHORT_MS     = 8,
  parameter int TRIP_LEVEL   = 64,
  parameter int MAG_W        = 4,
  parameter int TEMP_W       = 8,
  parameter int TEMP_TRIP    = 145,
  parameter int TEMP_CLEAR   = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ovFlag,
  input  logic [MAG_W-1:0]  ovMag,
  input  logic [TEMP_W-1:0] dieTemp,
  input  seqStrobe_t        strobe,
  output logic              tick,
  output logic              ovTrip,
  output logic              otActive,
  output logic              waitHit
);

  localparam int LONG_TICKS  = LONG_MS * TICKS_PER_MS;
  localparam int SHORT_TICKS = SHORT_MS * TICKS_PER_MS;
  localparam int WAIT_W      = $clog2(LONG_TICKS + 1);
  localparam int INT_W       = $clog2(TRIP_LEVEL + 1);
  localparam int SUM_W       = INT_W + MAG_W + 1;

  // tick prescaler
  generate
    if (CLK_PER_TICK == 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CLK_PER_TICK);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PRE_W'(CLK_PER_TICK - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(CLK_PER_TICK - 1));
    end
  endgenerate

  // overvoltage integrator
  logic [INT_W-1:0] integ;
  logic [SUM_W-1:0] upSum;
  assign upSum = SUM_W'(integ) + SUM_W'(ovMag) + SUM_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ <= '0;
    end else if (tick) begin
      if (ovFlag)
        integ <= (upSum >= SUM_W'(TRIP_LEVEL)) ? INT_W'(TRIP_LEVEL) : upSum[INT_W-1:0];
      else if (integ != '0)
        integ <= integ - 1'b1;
    end
  end
  assign ovTrip = (integ == INT_W'(TRIP_LEVEL));

  AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    integ <= INT_W'(TRIP_LEVEL)); // R7
  AST_INTEG_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !ovFlag && integ != '0) |=> integ == $past(integ) - 1'b1); // R7

  // thermal latch with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) otActive <= 1'b0;
    else if (dieTemp > TEMP_W'(TEMP_TRIP)) otActive <= 1'b1;
    else if (dieTemp < TEMP_W'(TEMP_CLEAR)) otActive <= 1'b0;
  end

  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (otActive && dieTemp >= TEMP_W'(TEMP_CLEAR)) |=> otActive); // R6

  // recovery window counter
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitNext;
  logic [WAIT_W-1:0] waitLimit;
  assign waitNext  = waitCnt + 1'b1;
  assign waitLimit = strobe.useLong ? WAIT_W'(LONG_TICKS) : WAIT_W'(SHORT_TICKS);
  assign waitHit   = strobe.stepWait && (waitNext == waitLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.clrWait) waitCnt <= '0;
    else if (strobe.stepWait) waitCnt <= waitNext;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_W'(LONG_TICKS)); // R4
  AST_WAIT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrWait |=> waitCnt == '0); // R4

endmodule

// File: rtl/vbus_seq_control.sv
module vbus_seq_control
  import vbus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvFlag,
  input  logic       tick,
  input  logic       ovTrip,
  input  logic       otActive,
  input  logic       waitHit,
  output seqStrobe_t strobe,
  output logic       ready
);

  faultSrc_t faultSrc;
  logic      faultAny;
  logic      longSel;

  // fixed priority: thermal, undervoltage, overvoltage
  always_comb begin
    if (otActive)    faultSrc = FLT_THERM;
    else if (uvFlag) faultSrc = FLT_UNDER;
    else if (ovTrip) faultSrc = FLT_OVER;
    else             faultSrc = FLT_NONE;
  end
  assign faultAny = (faultSrc != FLT_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      longSel <= 1'b1;
      ready   <= 1'b0;
    end else begin
      if (faultAny) longSel <= (faultSrc != FLT_OVER);
      if (faultAny) ready <= 1'b0;
      else if (waitHit) ready <= 1'b1;
    end
  end

  assign strobe.clrWait  = faultAny;
  assign strobe.stepWait = !faultAny && !ready && tick;
  assign strobe.useLong  = longSel;

  AST_FAULT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    faultAny |=> !ready); // R2
  AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(waitHit)); // R4
  AST_SHORT_ONLY_OV: assert property (@(posedge clk) disable iff (!rstN)
    (uvFlag || otActive) |=> longSel); // R8

endmodule

// File: rtl/vbus_guard_seq.sv
module vbus_guard_seq
  import vbus_seq_pkg::*;
#(
  parameter int CLK_PER_TICK = 125,
  parameter int TICKS_PER_MS = 1000,
  parameter int LONG_MS      = 17,
  parameter int SHORT_MS     = 8,
  parameter int TRIP_LEVEL   = 64,
  parameter int MAG_W        = 4,
  parameter int TEMP_W       = 8,
  parameter int TEMP_TRIP    = 145,
  parameter int TEMP_CLEAR   = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic [MAG_W-1:0]  ovMag,
  input  logic [TEMP_W-1:0] dieTemp,
  input  logic              enN,
  output logic              swOn,
  output logic              ackPullLow
);

  seqStrobe_t strobe;
  logic       tick;
  logic       ovTrip;
  logic       otActive;
  logic       waitHit;
  logic       ready;

  vbus_seq_datapath #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .TICKS_PER_MS (TICKS_PER_MS),
    .LONG_MS      (LONG_MS),
    .SHORT_MS     (SHORT_MS),
    .TRIP_LEVEL   (TRIP_LEVEL),
    .MAG_W        (MAG_W),
    .TEMP_W       (TEMP_W),
    .TEMP_TRIP    (TEMP_TRIP),
    .TEMP_CLEAR   (TEMP_CLEAR)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ovFlag   (ovFlag),
    .ovMag    (ovMag),
    .dieTemp  (dieTemp),
    .strobe   (strobe),
    .tick     (tick),
    .ovTrip   (ovTrip),
    .otActive (otActive),
    .waitHit  (waitHit)
  );

  vbus_seq_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .uvFlag   (uvFlag),
    .tick     (tick),
    .ovTrip   (ovTrip),
    .otActive (otActive),
    .waitHit  (waitHit),
    .strobe   (strobe),
    .ready    (ready)
  );

  assign ackPullLow = ready;
  assign swOn       = ready && !enN;

  AST_SW_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    swOn |-> ackPullLow); // R5
  AST_UV_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> !ackPullLow && !swOn); // R2

endmodule

// File: tb/test_vbus_guard_seq.sv
module test_vbus_guard_seq;

  localparam int CPT   = 1;
  localparam int TPM   = 4;
  localparam int TRIP  = 16;
  localparam int MAGW  = 3;
  localparam int LONGT = 17 * TPM;
  localparam int SHRTT = 8 * TPM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvFlag = 1'b0;
  logic ovFlag = 1'b0;
  logic [MAGW-1:0] ovMag = '0;
  logic [7:0] dieTemp = 8'd40;
  logic enN = 1'b0;
  logic swOn;
  logic ackPullLow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vbus_guard_seq #(
    .CLK_PER_TICK (CPT),
    .TICKS_PER_MS (TPM),
    .TRIP_LEVEL   (TRIP),
    .MAG_W        (MAGW)
  ) i_vbus_guard_seq (
    .clk        (clk),
    .rstN       (rstN),
    .uvFlag     (uvFlag),
    .ovFlag     (ovFlag),
    .ovMag      (ovMag),
    .dieTemp    (dieTemp),
    .enN        (enN),
    .swOn       (swOn),
    .ackPullLow (ackPullLow)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // bracket a recovery: ack still low one edge before, high on the edge
  task automatic expectRise(input string req, input int n);
    edges(n - 1);
    chk(req, ackPullLow, 1'b0);
    edges(1);
    chk(req, ackPullLow, 1'b1);
    chk(req, swOn, ~enN);
  endtask

  initial begin
    edges(3);
    chk("R1 reset ack", ackPullLow, 1'b0);
    chk("R1 reset sw", swOn, 1'b0);
    rstN = 1'b1;
    expectRise("R1 startup", LONGT);

    // R5: enable only gates the switch
    enN = 1'b1;
    #1;
    chk("R5 enN high sw", swOn, 1'b0);
    chk("R5 enN high ack", ackPullLow, 1'b1);
    edges(5);
    chk("R5 ack steady", ackPullLow, 1'b1);
    enN = 1'b0;
    #1;
    chk("R5 enN low sw", swOn, 1'b1);
    edges(1);

    // R2: undervoltage fault and recovery
    uvFlag = 1'b1;
    edges(1);
    chk("R2 uv release", ackPullLow, 1'b0);
    chk("R2 uv sw", swOn, 1'b0);
    edges(10);
    uvFlag = 1'b0;
    expectRise("R2 uv recovery", LONGT);

    // R4: one-cycle glitch inside a window restarts it
    uvFlag = 1'b1;
    edges(1);
    uvFlag = 1'b0;
    edges(30);
    uvFlag = 1'b1;
    edges(1);
    uvFlag = 1'b0;
    expectRise("R4 restart", LONGT);

    // R7 + R3: every magnitude code
    for (int m = 0; m < (1 << MAGW); m++) begin
      int k0;
      bit dropped;
      k0 = (TRIP + m) / (m + 1);
      ovMag = MAGW'(m);
      if (k0 > 1) begin
        dropped = 1'b0;
        ovFlag = 1'b1;
        for (int i = 0; i < k0 - 1; i++) begin
          edges(1);
          if (!ackPullLow) dropped = 1'b1;
        end
        ovFlag = 1'b0;
        for (int i = 0; i < TRIP + 2; i++) begin
          edges(1);
          if (!ackPullLow) dropped = 1'b1;
        end
        chk("R7 short pulse rejected", dropped, 1'b0);
      end
      ovFlag = 1'b1;
      edges(k0);
      chk("R7 before trip", ackPullLow, 1'b1);
      edges(1);
      chk("R7 trip time", ackPullLow, 1'b0);
      edges(3);
      ovFlag = 1'b0;
      expectRise("R3 ov recovery", 1 + SHRTT);
      edges(TRIP);
    end

    // R8: undervoltage present while overvoltage ends -> long window
    ovMag = MAGW'(7);
    ovFlag = 1'b1;
    edges(4);
    chk("R8 ov tripped", ackPullLow, 1'b0);
    uvFlag = 1'b1;
    ovFlag = 1'b0;
    edges(TRIP + 4);
    uvFlag = 1'b0;
    expectRise("R8 long after uv", LONGT);

    // R6: thermal thresholds
    begin
      bit dropped;
      dropped = 1'b0;
      for (int t = 100; t <= 145; t++) begin
        dieTemp = 8'(t);
        edges(1);
        if (!ackPullLow) dropped = 1'b1;
      end
      edges(2);
      if (!ackPullLow) dropped = 1'b1;
      chk("R6 no trip at 145", dropped, 1'b0);
    end
    dieTemp = 8'd146;
    edges(1);
    chk("R6 one edge latency", ackPullLow, 1'b1);
    edges(1);
    chk("R6 trip above 145", ackPullLow, 1'b0);
    dieTemp = 8'd120;
    edges(LONGT + 5);
    chk("R6 hold at 120", ackPullLow, 1'b0);
    dieTemp = 8'd119;
    expectRise("R6 thermal recovery", 1 + LONGT);

    // R1: reset mid-operation
    rstN = 1'b0;
    edges(1);
    chk("R1 reset clears ack", ackPullLow, 1'b0);
    rstN = 1'b1;
    expectRise("R1 restart window", LONGT);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule